// File: doc/BRIEF.md
# Interrupt Event Status Capture Queue

This block keeps a record of the status word for every occurrence of a hardware event that repeats. When the event strobe fires, the block copies the live status word into a first-in first-out store. The live status may change afterwards without affecting the copy. Firmware may service the interrupt many cycles later. It then pulls the stored words one at a time through a read port, oldest first, and handles each occurrence in turn.

The interrupt flag is not stored for each occurrence. One pending output covers every entry in the store, and it feeds a single source bit in an interrupt register bank downstream. Each accepted capture makes a fresh rising edge on this output, so a source bit that an edge sets again after firmware cleared it is set once more. The block also reports how many entries it holds. A sticky flag records that an event arrived while the store was full. Reading or popping changes nothing except the queue itself.

Top module: `evt_status_queue`

## Requirements
- R1: After reset, level_o is 0, pending_o is 0, overflow_o is 0 and rd_data_o is 0.
- R2: An accepted event stores the value status_i has at that clock edge. Later changes of status_i do not alter the stored word.
- R3: rd_data_o shows the oldest stored word combinationally. A pop_i at a clock edge removes that word, and the next oldest word appears after the edge.
- R4: level_o equals the number of stored words. It rises by one after each accepted capture and falls by one after each pop of a non-empty queue, and it never exceeds DEPTH.
- R5: When a pop of a non-empty queue and an event fall on the same edge, both take effect and level_o keeps its value.
- R6: An event at an edge where the queue is full and no pop occurs is discarded. overflow_o is 1 after that edge, level_o stays at DEPTH and the stored words are unchanged.
- R7: Once set, overflow_o stays 1 until an edge with ovf_clr_i high. If an overflow occurs at the same edge as ovf_clr_i, the set wins.
- R8: After an edge with an accepted capture, pending_o is 1 if it was 0 before that edge and the queue is non-empty, and it is 0 if it was 1 before that edge. After any other edge, pending_o is 1 exactly when level_o is not 0.
- R9: A pop while the queue is empty has no effect, and rd_data_o reads 0 whenever the queue is empty.
- R10: An event at an edge where the queue is full and a pop occurs is accepted. overflow_o is not set, and level_o stays at DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| event_i | input | 1 | One-cycle strobe marking an event occurrence |
| status_i | input | SW | Live status word, copied when an event is accepted |
| pop_i | input | 1 | Removes the oldest stored word at the clock edge |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| rd_data_o | output | SW | Oldest stored word, or 0 when the queue is empty |
| pending_o | output | 1 | Interrupt source to the register bank |
| level_o | output | clog2(DEPTH+1) | Number of stored words |
| overflow_o | output | 1 | Sticky flag: an event was lost because the queue was full |

## Verification
The hardest cases to reach are at a full queue: an event with a pop on the same edge must be accepted, and an event with no pop must be dropped. Each needs the queue filled exactly to DEPTH first. A clear of the overflow flag on the same edge as a fresh overflow is also hard to hit. The bench uses a small configuration (DEPTH 4, 8-bit words). It fills the queue with directed steps, applies each of these combinations on purpose, then runs a long pseudo-random sweep of event, pop and clear. Across thousands of edges the sweep reaches full and empty many times. A reference queue in the bench predicts every output on every cycle, including the one-cycle gap in pending_o after a capture into a queue that is not empty.

// File: rtl/esq_pkg.sv
package esq_pkg;

  // Decisions of one cycle, shared between the control and flag logic.
  typedef struct packed {
    logic push;   // event accepted into the store
    logic pop;    // oldest entry removed
    logic drop;   // event lost because the store is full
  } esq_ctl_t;

  // Circular pointer advance for a store of 'depth' entries.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Occupancy after one edge.
  function automatic int unsigned level_after(input int unsigned lvl, input logic push,
                                              input logic pop);
    int unsigned n;
    n = lvl;
    if (push) n = n + 1;
    if (pop)  n = n - 1;
    return n;
  endfunction

endpackage

// File: rtl/esq_ctl.sv
module esq_ctl
  import esq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PW    = 3,
  parameter int unsigned LW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          event_i,
  input  logic          pop_i,
  output esq_ctl_t      ctl_o,
  output logic [PW-1:0] wr_ptr_o,
  output logic [PW-1:0] rd_ptr_o,
  output logic [LW-1:0] level_o,
  output logic          empty_o,
  output logic          nz_next_o
);

  logic [LW-1:0] lvl_q;
  logic [PW-1:0] wp_q, rp_q;
  logic          full, empty, pop_ok, push_ok, drop;
  int unsigned   lvl_n;

  assign full    = (lvl_q == LW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign pop_ok  = pop_i && !empty;
  assign push_ok = event_i && (!full || pop_ok);
  assign drop    = event_i && !push_ok;
  assign lvl_n   = level_after(32'(lvl_q), push_ok, pop_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
    end else begin
      lvl_q <= LW'(lvl_n);
      if (push_ok) wp_q <= PW'(wrap_inc(32'(wp_q), DEPTH));
      if (pop_ok)  rp_q <= PW'(wrap_inc(32'(rp_q), DEPTH));
    end
  end

  assign ctl_o     = '{push: push_ok, pop: pop_ok, drop: drop};
  assign wr_ptr_o  = wp_q;
  assign rd_ptr_o  = rp_q;
  assign level_o   = lvl_q;
  assign empty_o   = empty;
  assign nz_next_o = (lvl_n != 0);

endmodule

// File: rtl/esq_store.sv
module esq_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SW    = 16,
  parameter int unsigned PW    = 3
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [PW-1:0] waddr_i,
  input  logic [SW-1:0] wdata_i,
  input  logic [PW-1:0] raddr_i,
  output logic [SW-1:0] rdata_o
);

  logic [SW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we_i && (waddr_i == PW'(i))) mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/esq_irq.sv
module esq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic drop_i,
  input  logic ovf_clr_i,
  input  logic nz_next_i,
  output logic pending_o,
  output logic overflow_o
);

  logic pend_q, ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      // a capture into a queue that already signals drops the line for one
      // cycle so the downstream source bit sees a new rising edge
      pend_q <= nz_next_i && !(push_i && pend_q);
      if (drop_i)         ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  assign pending_o  = pend_q;
  assign overflow_o = ovf_q;

endmodule

// File: rtl/evt_status_queue.sv
module evt_status_queue
  import esq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SW    = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         event_i,
  input  logic [SW-1:0]                status_i,
  input  logic                         pop_i,
  input  logic                         ovf_clr_i,
  output logic [SW-1:0]                rd_data_o,
  output logic                         pending_o,
  output logic [$clog2(DEPTH+1)-1:0]   level_o,
  output logic                         overflow_o
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LW = $clog2(DEPTH + 1);

  esq_ctl_t      ctl;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [SW-1:0] head_word;
  logic          q_empty, nz_next;

  // named event wires for the checker
  logic cap_push, cap_pop, cap_drop;
  assign cap_push = ctl.push;
  assign cap_pop  = ctl.pop;
  assign cap_drop = ctl.drop;

  esq_ctl #(.DEPTH(DEPTH), .PW(PW), .LW(LW)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .event_i  (event_i),
    .pop_i    (pop_i),
    .ctl_o    (ctl),
    .wr_ptr_o (wr_ptr),
    .rd_ptr_o (rd_ptr),
    .level_o  (level_o),
    .empty_o  (q_empty),
    .nz_next_o(nz_next)
  );

  esq_store #(.DEPTH(DEPTH), .SW(SW), .PW(PW)) u_store (
    .clk    (clk),
    .we_i   (ctl.push),
    .waddr_i(wr_ptr),
    .wdata_i(status_i),
    .raddr_i(rd_ptr),
    .rdata_o(head_word)
  );

  esq_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (ctl.push),
    .drop_i    (ctl.drop),
    .ovf_clr_i (ovf_clr_i),
    .nz_next_i (nz_next),
    .pending_o (pending_o),
    .overflow_o(overflow_o)
  );

  assign rd_data_o = q_empty ? '0 : head_word;

endmodule

// File: rtl/esq_chk.sv
module esq_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SW    = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ovf_clr_i,
  input logic [SW-1:0]              rd_data_o,
  input logic                       pending_o,
  input logic [$clog2(DEPTH+1)-1:0] level_o,
  input logic                       overflow_o,
  input logic                       cap_push,
  input logic                       cap_pop,
  input logic                       cap_drop
);

  localparam int unsigned LW = $clog2(DEPTH + 1);

  // R4
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= LW'(DEPTH));

  // R9
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == '0) |-> (rd_data_o == '0));

  // R5
  swap_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_push && cap_pop) |=> $stable(level_o));

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_drop |=> (overflow_o && level_o == LW'(DEPTH)));

  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !ovf_clr_i) |=> overflow_o);

  // R8
  pend_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending_o |-> (level_o != '0));

endmodule

bind evt_status_queue esq_chk #(.DEPTH(DEPTH), .SW(SW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ovf_clr_i (ovf_clr_i),
  .rd_data_o (rd_data_o),
  .pending_o (pending_o),
  .level_o   (level_o),
  .overflow_o(overflow_o),
  .cap_push  (cap_push),
  .cap_pop   (cap_pop),
  .cap_drop  (cap_drop)
);

// File: tb/sim_evt_status_queue.sv
`timescale 1ns/1ps
module sim_evt_status_queue;

  localparam int D = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         event_i, pop_i, ovf_clr_i;
  logic [W-1:0] status_i;
  logic [W-1:0] rd_data_o;
  logic         pending_o, overflow_o;
  logic [2:0]   level_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // reference state
  logic [W-1:0] mq [D];
  int  mc;
  bit  mp, mo;

  always #2 clk = ~clk;

  evt_status_queue #(.DEPTH(D), .SW(W)) u0 (
    .clk(clk), .rst_n(rst_n), .event_i(event_i), .status_i(status_i),
    .pop_i(pop_i), .ovf_clr_i(ovf_clr_i), .rd_data_o(rd_data_o),
    .pending_o(pending_o), .level_o(level_o), .overflow_o(overflow_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "level_o", int'(level_o), mc);
    check(tag, "rd_data_o", int'(rd_data_o), (mc != 0) ? int'(mq[0]) : 0);
    check(tag, "pending_o", int'(pending_o), int'(mp));
    check(tag, "overflow_o", int'(overflow_o), int'(mo));
  endtask

  task automatic model(input bit ev, input logic [W-1:0] st, input bit pp, input bit cl);
    bit dpop, acc;
    dpop = pp && (mc != 0);
    acc  = ev && ((mc != D) || dpop);
    if (dpop) begin
      for (int k = 0; k < D - 1; k++) mq[k] = mq[k+1];
      mc = mc - 1;
    end
    if (acc) begin
      mq[mc] = st;
      mc = mc + 1;
    end
    if (acc) mp = (mc != 0) && !mp;
    else     mp = (mc != 0);
    if (ev && !acc) mo = 1'b1;
    else if (cl)    mo = 1'b0;
  endtask

  // called at a falling edge: check outputs, drive, advance one edge
  task automatic step(input string tag, input bit ev, input logic [W-1:0] st,
                      input bit pp, input bit cl);
    compare(tag);
    event_i = ev; status_i = st; pop_i = pp; ovf_clr_i = cl;
    @(posedge clk);
    model(ev, st, pp, cl);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0; event_i = 0; pop_i = 0; ovf_clr_i = 0; status_i = '0;
    mc = 0; mp = 0; mo = 0;
    for (int k = 0; k < D; k++) mq[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare("R1");

    // R9: pop on empty does nothing
    step("R9", 0, 8'h00, 1, 0);
    step("R9", 0, 8'h5A, 1, 0);
    // R2: stored word keeps the value captured at the edge
    step("R2", 1, 8'h11, 0, 0);
    step("R2", 0, 8'h99, 0, 0);
    step("R2", 0, 8'h77, 0, 0);
    // R8: captures into a non-empty queue pulse pending low
    step("R8", 1, 8'h22, 0, 0);
    step("R8", 1, 8'h33, 0, 0);
    step("R8", 0, 8'h00, 0, 0);
    step("R8", 1, 8'h44, 0, 0);
    step("R8", 0, 8'h00, 0, 0);
    // R6: full, event without pop is dropped
    step("R6", 1, 8'hE1, 0, 0);
    step("R6", 1, 8'hE2, 0, 0);
    step("R6", 0, 8'h00, 0, 0);
    // R7: overflow again with clear on the same edge, then clear alone
    step("R7", 1, 8'hE3, 0, 1);
    step("R7", 0, 8'h00, 0, 0);
    step("R7", 0, 8'h00, 0, 1);
    step("R7", 0, 8'h00, 0, 0);
    // R10: full, event with pop is accepted
    step("R10", 1, 8'h55, 1, 0);
    step("R10", 0, 8'h00, 0, 0);
    // R5: pop and capture in a partly filled queue
    step("R5", 0, 8'h00, 1, 0);
    step("R5", 1, 8'h66, 1, 0);
    step("R5", 0, 8'h00, 0, 0);
    // R3: drain oldest first, then pop past empty
    for (int k = 0; k < D + 2; k++) step("R3", 0, 8'h00, 1, 0);

    // R4: long pseudo-random sweep of event, pop and clear
    lf = 16'hACE1;
    for (int n = 0; n < 6000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("R4", lf[0], lf[15:8], lf[1] & (lf[2] | lf[3]), lf[5] & lf[6] & lf[7]);
    end
    compare("R4");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule